// File: doc/BRIEF.md
# Transmit descriptor ring engine

This block serves a ring of sixteen transmit descriptors that the host keeps in a shared descriptor memory. A one-cycle demand pulse starts a scan at the current ring position. For each entry that the host has handed over as a whole packet, the engine does four things in order. It reads the entry's length word, which holds the byte count as a negative number. It reads the packet bytes from that entry's fixed buffer slot and presents them on a valid/ready/last byte stream. It writes the entry's status and error words back. It then raises a one-cycle done pulse, which the surrounding controller turns into its transmit-interrupt flags.

The scan stops at the first entry that is not ready, or after sixteen entries. The ring pointer moves on by one, modulo the ring size, for every packet sent. It keeps its value between scans. While the controller is stopped (`run_en` low), no descriptor is touched. Each of the two memory ports returns read data one cycle after the request.

Top module: `txd_ring_engine`

## Requirements
- R1: Out of reset, `tx_valid`, `tx_last`, `tx_done` and `busy` are low and `ring_ptr` is 0.
- R2: A `tx_demand` pulse seen while idle and running starts a scan at `ring_ptr`. Entries are served in ring order, and the scan ends at the first entry that is not ready. Entry i occupies descriptor words 4*i+0 to 4*i+3.
- R3: An entry is ready only when the upper byte (bits 15:8) of its word 1 equals 0x83 exactly. Any other value, for example 0x82 or 0xC3, ends the scan with nothing sent and `ring_ptr` unchanged.
- R4: Word 2 holds the negated byte count as a 16-bit two's-complement number. The bytes sent are its 16-bit negation. A result of 0, or one larger than BUF_BYTES (1544), sends BUF_BYTES bytes.
- R5: Byte j of entry i is read from buffer address i*BUF_BYTES + j, and bytes leave in ascending j. `tx_last` is high on the final byte only.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values on the next cycle.
- R7: After a packet, word 1 becomes 0x03 in its upper byte with the lower byte unchanged, and word 3 becomes 0.
- R8: Each packet sent gives exactly one single-cycle `tx_done` pulse, and `ring_ptr` advances by one modulo 16 on the edge that ends it.
- R9: While `run_en` is low, a demand starts nothing: no descriptor read or write occurs, and the ring state and descriptors are left unchanged.
- R10: One scan serves at most 16 entries, so a fully armed ring sends 16 packets and returns `ring_ptr` to its starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Controller running; low means stopped |
| tx_demand | input | 1 | One-cycle request to scan the ring |
| desc_rd_en | output | 1 | Descriptor word read request |
| desc_wr_en | output | 1 | Descriptor word write strobe |
| desc_addr | output | 6 | Descriptor word address |
| desc_wdata | output | 16 | Descriptor write data |
| desc_rdata | input | 16 | Descriptor read data, one cycle after the request |
| buf_rd_en | output | 1 | Packet buffer byte read request |
| buf_addr | output | 15 | Packet buffer byte address |
| buf_rdata | input | 8 | Buffer read data, one cycle after the request |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_done | output | 1 | One-cycle pulse per packet sent |
| busy | output | 1 | Scan in progress |
| ring_ptr | output | 4 | Next ring entry to examine |

## Verification
The assertions take three things for granted. Both memory ports return data exactly one cycle after a request. `tx_demand` is a single-cycle pulse. The host leaves the descriptors alone while `busy` is high, because the ready check and the write-back assume no other writer. The bench keeps to these rules. Its memory model registers every read. It pulses the demand for one cycle. It edits descriptors only after `busy` has fallen, and the stop test drops `run_en` only between scans.

// File: rtl/txr_pkg.sv
package txr_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_STAT_RD, S_STAT_CHK, S_LEN_RD, S_LEN_CHK,
    S_FETCH, S_LATCH, S_SEND, S_WB_STAT, S_WB_ERR
  } txr_state_e;

  localparam logic [7:0] STAT_ARMED = 8'h83;  // owned, start and end of packet
  localparam logic [7:0] STAT_SENT  = 8'h03;  // ownership returned to host

  // Byte count from the negated length field, clamped to one buffer.
  function automatic logic [15:0] byte_count(input logic [15:0] len_field,
                                             input logic [15:0] cap);
    logic [15:0] n;
    n = 16'(~len_field + 16'd1);
    if (n == 16'd0 || n > cap) return cap;
    return n;
  endfunction

endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
  parameter int RING_LOG = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scan_clr,
  input  logic                adv,
  output logic [RING_LOG-1:0] ptr,
  output logic                scan_full
);
  localparam int RING = 1 << RING_LOG;

  logic [RING_LOG:0] scan_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      scan_cnt <= '0;
    end else begin
      if (scan_clr) scan_cnt <= '0;
      else if (adv) scan_cnt <= scan_cnt + 1'b1;
      if (adv) ptr <= ptr + 1'b1;
    end
  end

  assign scan_full = (scan_cnt == (RING_LOG+1)'(RING));

  // R10
  scan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (scan_cnt < (RING_LOG+1)'(RING)));

endmodule

// File: rtl/txr_byte_cnt.sv
module txr_byte_cnt #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic [CW-1:0] idx,
  output logic          last
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      idx    <= '0;
    end else if (load) begin
      remain <= load_val;
      idx    <= '0;
    end else if (step) begin
      remain <= remain - 1'b1;
      idx    <= idx + 1'b1;
    end
  end

  assign last = (remain == CW'(1));

  // R4
  load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (remain != '0));

  // R5
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (idx == $past(idx) + 1'b1));

endmodule

// File: rtl/txd_ring_engine.sv
module txd_ring_engine #(
  parameter int RING_LOG  = 4,
  parameter int BUF_BYTES = 1544,
  localparam int RING     = 1 << RING_LOG,
  localparam int DESC_AW  = RING_LOG + 2,
  localparam int BUF_AW   = $clog2(RING * BUF_BYTES),
  localparam int CW       = $clog2(BUF_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic                tx_demand,
  output logic                desc_rd_en,
  output logic                desc_wr_en,
  output logic [DESC_AW-1:0]  desc_addr,
  output logic [15:0]         desc_wdata,
  input  logic [15:0]         desc_rdata,
  output logic                buf_rd_en,
  output logic [BUF_AW-1:0]   buf_addr,
  input  logic [7:0]          buf_rdata,
  output logic                tx_valid,
  output logic [7:0]          tx_data,
  output logic                tx_last,
  input  logic                tx_ready,
  output logic                tx_done,
  output logic                busy,
  output logic [RING_LOG-1:0] ring_ptr
);
  import txr_pkg::*;

  txr_state_e    st, st_nx;
  logic [7:0]    hi_q, byte_q;
  logic          scan_full, cnt_last, cnt_load, cnt_step, beat;
  logic [CW-1:0] cnt_idx, cnt_val;

  // named internal events
  logic scan_start, entry_armed, pkt_done;

  assign scan_start  = (st == S_IDLE) && tx_demand && run_en;
  assign entry_armed = (desc_rdata[15:8] == STAT_ARMED);
  assign beat        = (st == S_SEND) && tx_ready;
  assign pkt_done    = (st == S_WB_ERR);
  assign cnt_load    = (st == S_LEN_CHK);
  assign cnt_step    = beat && !cnt_last;
  assign cnt_val     = CW'(byte_count(desc_rdata, 16'(BUF_BYTES)));

  txr_ring_ptr #(.RING_LOG(RING_LOG)) u_ptr (
    .clk(clk), .rst_n(rst_n), .scan_clr(scan_start), .adv(pkt_done),
    .ptr(ring_ptr), .scan_full(scan_full)
  );

  txr_byte_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .step(cnt_step), .idx(cnt_idx), .last(cnt_last)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:     if (scan_start) st_nx = S_STAT_RD;
      S_STAT_RD:  st_nx = (run_en && !scan_full) ? S_STAT_CHK : S_IDLE;
      S_STAT_CHK: st_nx = entry_armed ? S_LEN_RD : S_IDLE;
      S_LEN_RD:   st_nx = S_LEN_CHK;
      S_LEN_CHK:  st_nx = S_FETCH;
      S_FETCH:    st_nx = S_LATCH;
      S_LATCH:    st_nx = S_SEND;
      S_SEND:     if (tx_ready) st_nx = cnt_last ? S_WB_STAT : S_FETCH;
      S_WB_STAT:  st_nx = S_WB_ERR;
      S_WB_ERR:   st_nx = S_STAT_RD;
      default:    st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      hi_q   <= '0;
      byte_q <= '0;
    end else begin
      st <= st_nx;
      if (st == S_STAT_CHK) hi_q <= desc_rdata[7:0];
      if (st == S_LATCH) byte_q <= buf_rdata;
    end
  end

  always_comb begin
    unique case (st)
      S_STAT_RD, S_WB_STAT: desc_addr = {ring_ptr, 2'd1};
      S_LEN_RD:             desc_addr = {ring_ptr, 2'd2};
      S_WB_ERR:             desc_addr = {ring_ptr, 2'd3};
      default:              desc_addr = {ring_ptr, 2'd0};
    endcase
  end

  assign desc_rd_en = ((st == S_STAT_RD) && run_en && !scan_full) || (st == S_LEN_RD);
  assign desc_wr_en = (st == S_WB_STAT) || (st == S_WB_ERR);
  assign desc_wdata = (st == S_WB_STAT) ? {STAT_SENT, hi_q} : 16'h0000;
  assign buf_rd_en  = (st == S_FETCH);
  assign buf_addr   = BUF_AW'(ring_ptr) * BUF_AW'(BUF_BYTES) + BUF_AW'(cnt_idx);
  assign tx_valid   = (st == S_SEND);
  assign tx_data    = byte_q;
  assign tx_last    = (st == S_SEND) && cnt_last;
  assign tx_done    = pkt_done;
  assign busy       = (st != S_IDLE);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R8
  ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> (ring_ptr == RING_LOG'($past(ring_ptr) + 1'b1)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  // R5
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_IDLE) && !run_en) |=> !desc_rd_en && !desc_wr_en);

  // R3
  armed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STAT_CHK && !entry_armed) |=> !busy);

  // R2
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({desc_rd_en, desc_wr_en, buf_rd_en}));

endmodule

// File: tb/txd_ring_engine_bench.sv
`timescale 1ns/1ps
module txd_ring_engine_bench;
  localparam int RING = 16;
  localparam int BB   = 1544;

  logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0, tx_demand = 1'b0, tx_ready = 1'b0;
  logic desc_rd_en, desc_wr_en, buf_rd_en, tx_valid, tx_last, tx_done, busy;
  logic [5:0]  desc_addr;
  logic [15:0] desc_wdata, desc_rdata;
  logic [14:0] buf_addr;
  logic [7:0]  buf_rdata, tx_data;
  logic [3:0]  ring_ptr;

  always #2 clk = ~clk;

  txd_ring_engine u_txd_ring_engine (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tx_demand(tx_demand),
    .desc_rd_en(desc_rd_en), .desc_wr_en(desc_wr_en), .desc_addr(desc_addr),
    .desc_wdata(desc_wdata), .desc_rdata(desc_rdata), .buf_rd_en(buf_rd_en),
    .buf_addr(buf_addr), .buf_rdata(buf_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .tx_done(tx_done), .busy(busy), .ring_ptr(ring_ptr)
  );

  // memory model
  logic [15:0] dmem [0:63];
  logic [7:0]  seed = 8'h00;
  logic        host_we = 1'b0;
  logic [5:0]  host_a = '0;
  logic [15:0] host_d = '0;

  function automatic logic [7:0] pat(input int a, input logic [7:0] s);
    return 8'((a * 13) + (a >> 3) + int'(s));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 64; k++) dmem[k] <= 16'h0000;
    end else begin
      if (desc_rd_en) desc_rdata <= dmem[desc_addr];
      if (desc_wr_en) dmem[desc_addr] <= desc_wdata;
      if (host_we) dmem[host_a] <= host_d;
    end
    if (buf_rd_en) buf_rdata <= pat(int'(buf_addr), seed);
  end

  // reference state
  int n_cmp = 0, n_bad = 0, done_cnt = 0, exp_done = 0, rd_seen = 0, mptr = 0, cyc = 0;
  int rmode = 0;
  int          exp_b[$];
  bit          exp_l[$];
  bit          stall_prev = 0;
  logic [7:0]  prev_d;
  logic        prev_l;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_count(input logic [15:0] f);
    int n;
    n = (65536 - int'(f)) % 65536;
    if (n == 0 || n > BB) n = BB;
    return n;
  endfunction

  // per-cycle monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      tx_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1);
      if (stall_prev) begin
        // R6
        chk(tx_valid && tx_data == prev_d && tx_last == prev_l, "R6 hold",
            int'({tx_valid, tx_last, tx_data}), int'({1'b1, prev_l, prev_d}));
      end
      stall_prev = tx_valid && !tx_ready;
      prev_d = tx_data;
      prev_l = tx_last;
      if (tx_valid && tx_ready) begin
        if (exp_b.size() == 0) begin
          chk(1'b0, "R5 unexpected byte", int'(tx_data), -1);
        end else begin
          int eb;
          bit el;
          eb = exp_b.pop_front();
          el = exp_l.pop_front();
          // R5 / R4
          chk(int'(tx_data) == eb && tx_last == el, "R5 byte/last",
              int'({tx_last, tx_data}), int'({el, 8'(eb)}));
        end
      end
      if (tx_done) done_cnt++;
      if (desc_rd_en || desc_wr_en) rd_seen++;
    end
  end

  task automatic host_wr(input int a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_a = 6'(a); host_d = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic arm(input int i, input logic [15:0] lenf, input logic [7:0] hi);
    host_wr(i * 4 + 1, {8'h83, hi});
    host_wr(i * 4 + 2, lenf);
    host_wr(i * 4 + 3, 16'hBEEF);
  endtask

  task automatic run_scan(input string tag);
    int sidx[$];
    logic [7:0] shi[$];
    if (run_en) begin
      for (int k = 0; k < RING; k++) begin
        int i, n;
        i = mptr;
        if (dmem[i * 4 + 1][15:8] !== 8'h83) break;
        n = exp_count(dmem[i * 4 + 2]);
        for (int j = 0; j < n; j++) begin
          exp_b.push_back(int'(pat(i * BB + j, seed)));
          exp_l.push_back(j == n - 1);
        end
        sidx.push_back(i);
        shi.push_back(dmem[i * 4 + 1][7:0]);
        mptr = (mptr + 1) % RING;
        exp_done++;
      end
    end
    @(negedge clk) tx_demand = 1'b1;
    @(negedge clk) tx_demand = 1'b0;
    for (int w = 0; w < 20000 && busy; w++) @(negedge clk);
    @(negedge clk);
    chk(exp_b.size() == 0, {tag, " R5 all bytes sent"}, exp_b.size(), 0);
    chk(done_cnt == exp_done, {tag, " R8 done pulses"}, done_cnt, exp_done);
    chk(int'(ring_ptr) == mptr, {tag, " R8 ring pointer"}, int'(ring_ptr), mptr);
    foreach (sidx[q]) begin
      // R7
      chk(dmem[sidx[q] * 4 + 1] == {8'h03, shi[q]}, {tag, " R7 status word"},
          int'(dmem[sidx[q] * 4 + 1]), int'({8'h03, shi[q]}));
      chk(dmem[sidx[q] * 4 + 3] == 16'h0000, {tag, " R7 error word"},
          int'(dmem[sidx[q] * 4 + 3]), 0);
    end
    exp_b.delete();
    exp_l.delete();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int rd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!tx_valid && !tx_last && !tx_done && !busy && ring_ptr == 4'd0, "R1 reset state",
        int'({tx_valid, tx_last, tx_done, busy, ring_ptr}), 0);

    // R2: three armed entries then an empty one
    run_en = 1'b1;
    seed = 8'h11;
    arm(0, 16'(-4), 8'h11);
    arm(1, 16'(-1), 8'h22);
    arm(2, 16'(-7), 8'h33);
    run_scan("R2 three packets");

    // R3: near-miss status values stop the scan
    arm(4, 16'(-3), 8'h99);
    host_wr(3 * 4 + 1, 16'h8244);
    run_scan("R3 status 0x82");
    host_wr(3 * 4 + 1, 16'hC344);
    run_scan("R3 status 0xC3");

    // R6: backpressure on a three-packet scan
    rmode = 1;
    seed = 8'h5A;
    arm(3, 16'(-5), 8'h44);
    arm(4, 16'(-3), 8'h55);
    arm(5, 16'(-9), 8'h66);
    run_scan("R6 backpressure");
    rmode = 0;

    // R9: stopped controller ignores demand
    run_en = 1'b0;
    arm(6, 16'(-2), 8'h77);
    rd0 = rd_seen;
    run_scan("R9 stopped");
    chk(rd_seen == rd0, "R9 no descriptor access", rd_seen - rd0, 0);
    chk(dmem[6 * 4 + 1] == 16'h8377, "R9 descriptor untouched", int'(dmem[6 * 4 + 1]), 16'h8377);
    run_en = 1'b1;
    seed = 8'hC3;
    run_scan("R9 resumed");

    // R4: zero and positive length fields clamp to one buffer
    arm(7, 16'h0000, 8'h01);
    arm(8, 16'h0005, 8'h02);
    run_scan("R4 clamp");

    // R10: whole ring armed with backpressure
    rmode = 1;
    seed = 8'h3C;
    for (int i = 0; i < RING; i++) arm(i, 16'(-2), 8'(i));
    run_scan("R10 full ring");
    chk(ring_ptr == 4'd9, "R10 pointer wraps home", int'(ring_ptr), 9);
    rmode = 0;

    finish_run();
  end

endmodule